// File: doc/BRIEF.md
# Interleaved Strided Vector Memory

This block models a word-interleaved main memory that serves one vector transfer at a time. A command names a starting word address, a signed stride and an element count. An internal address generator then walks the vector, offering one element per cycle to one of sixteen banks of 64-bit words. The bank is picked by the low four address bits, so consecutive words land in consecutive banks.

Each bank needs a short recovery time after an access. The generator therefore holds the current element and raises a stall flag whenever that element's bank has not yet recovered. A unit-stride vector streams without a gap. A stride that keeps returning to one bank is slowed to one element per recovery window.

Store elements take their data from a ready/valid stream. Load elements come back after a fixed access latency, tagged with their element index and in ascending order. A single-cycle done pulse marks the end of each command.

Top module: `vec_bank_mem`

## Requirements
- R1: The memory holds 1024 words of 64 bits in 16 banks; word address bits [3:0] select the bank and bits [9:4] select the row within it.
- R2: Element i of a command is at word address (base + i*stride) mod 1024, where the stride is a 10-bit two's-complement value.
- R3: After a bank is accessed in cycle t, no element is issued to that same bank before cycle t+4.
- R4: When the current element's bank is free (and, for a store, data is valid), the element issues in that cycle, so a unit-stride vector issues one element per cycle with no stall.
- R5: `stall` is high exactly in the cycles where an active command's current element targets a busy bank; that element is held and issued later, never skipped.
- R6: A load element issued in cycle t appears on `ld_valid`/`ld_idx`/`ld_data` in cycle t+12, and load results leave in strictly ascending element order.
- R7: A store element consumes `st_data` in a cycle where both `st_valid` and `st_ready` are high; `st_ready` is high when an active store's current bank is free, and a low `st_valid` delays the element without losing it.
- R8: `cmd_len` (7 bits) gives the number of elements, from 1 to 64, and exactly that many elements are transferred.
- R9: A stride of zero is legal; every element accesses the same word, one access per 4-cycle bank window.
- R10: `done` is a one-cycle pulse, in the cycle after the last store element issues or the cycle after the last load result is presented; `busy` falls in the same cycle.
- R11: `cmd_valid` while `busy` is high is ignored and changes neither the running transfer nor memory contents.
- R12: After reset, `busy`, `stall`, `st_ready`, `ld_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_store | input | 1 | 1 = store vector, 0 = load vector |
| cmd_base | input | 10 | Starting word address |
| cmd_stride | input | 10 | Signed element stride in words |
| cmd_len | input | 7 | Element count, 1 to 64 |
| busy | output | 1 | A command is in progress |
| stall | output | 1 | Current element waits on a busy bank |
| st_valid | input | 1 | Store data valid |
| st_data | input | 64 | Store data for the current element |
| st_ready | output | 1 | Store data is taken this cycle if valid |
| ld_valid | output | 1 | Load result valid |
| ld_idx | output | 6 | Element index of the load result |
| ld_data | output | 64 | Load result word |
| done | output | 1 | Command completion pulse |

## Verification
A wrong bank-recovery counter shows up as a changed `stall` count and shifted `ld_valid` cycles within the first few elements of a non-unit stride. A wrong address accumulator or row/bank split returns a wrong `ld_data` word, 12 cycles after the bad element issues. A lost or skipped held element shortens the result stream and moves the `done` pulse, so the bench predicts every issue cycle from the bank window rule and compares result arrival, data, stall total and completion cycle for a sweep of strides, including zero, negative and wrapping ones.

// File: rtl/vbm_pkg.sv
// Shared types for the interleaved strided vector memory.
package vbm_pkg;
    // Address generator control state.
    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_ISSUE = 2'd1,
        GEN_DRAIN = 2'd2
    } gen_state_t;
endpackage

// File: rtl/vbm_addr_gen.sv
// Strided address generator.
// Walks one vector command element by element, presenting the current
// element address to the bank tracker and issuing it when its bank is
// free (and store data is valid). Assumes cmd_len is 1..MAX_VL and that
// load results come back in order through the load pipe.
module vbm_addr_gen
    import vbm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 7,
    parameter int IDX_W  = 6,
    parameter int BANKS  = 16,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [BANKS-1:0]  bank_busy,
    input  logic              st_valid,
    input  logic              drain_done,
    output logic              issue,
    output logic              issue_store,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [IDX_W-1:0]  issue_idx,
    output logic              issue_last,
    output logic              stall,
    output logic              st_ready,
    output logic              busy,
    output logic              done
);
    gen_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic              store_q;
    logic              done_q;
    logic              bank_free;

    // Issue decision for the current element.
    always_comb begin
        bank_free   = !bank_busy[addr_q[BANK_W-1:0]];
        issue       = (state_q == GEN_ISSUE) && bank_free && (!store_q || st_valid);
        stall       = (state_q == GEN_ISSUE) && !bank_free;
        st_ready    = (state_q == GEN_ISSUE) && store_q && bank_free;
        issue_last  = (idx_q == last_q);
        issue_addr  = addr_q;
        issue_idx   = idx_q;
        issue_store = store_q;
        busy        = (state_q != GEN_IDLE);
        done        = done_q;
    end

    // Command capture, element stepping and completion sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= GEN_IDLE;
            addr_q   <= '0;
            stride_q <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            store_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                GEN_IDLE: begin
                    if (cmd_valid) begin
                        state_q  <= GEN_ISSUE;
                        addr_q   <= cmd_base;
                        stride_q <= cmd_stride;
                        idx_q    <= '0;
                        last_q   <= IDX_W'(cmd_len - 1'b1);
                        store_q  <= cmd_store;
                    end
                end
                GEN_ISSUE: begin
                    if (issue) begin
                        addr_q <= addr_q + stride_q;
                        idx_q  <= idx_q + 1'b1;
                        if (issue_last) begin
                            state_q <= store_q ? GEN_IDLE : GEN_DRAIN;
                            done_q  <= store_q;
                        end
                    end
                end
                GEN_DRAIN: begin
                    if (drain_done) begin
                        state_q <= GEN_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

    // R2: each issued non-final element advances the address by the stride.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !issue_last) |=> (addr_q == $past(addr_q) + $past(stride_q)));

    // R5: a stalled element is held, not skipped.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(idx_q) && $stable(addr_q)));

    // R10: completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11: a running command's parameters do not change while busy.
    assert_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(last_q) && $stable(store_q) && $stable(stride_q)));
endmodule

// File: rtl/vbm_bank_track.sv
// Per-bank recovery tracker.
// Each bank has a small down-counter loaded on access; the bank reports
// busy until the counter returns to zero, giving BUSY_CYC cycles between
// accesses to one bank. Assumes BUSY_CYC >= 2.
module vbm_bank_track #(
    parameter int BANKS    = 16,
    parameter int BUSY_CYC = 4,
    localparam int BANK_W  = $clog2(BANKS),
    localparam int CNT_W   = $clog2(BUSY_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [BANK_W-1:0] issue_bank,
    output logic [BANKS-1:0]  bank_busy
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;

        // Load the recovery window on access, otherwise count it down.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (issue && (issue_bank == BANK_W'(g))) begin
                cnt_q <= CNT_W'(BUSY_CYC - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign bank_busy[g] = (cnt_q != '0);
    end

    // R3: two consecutive cycles never issue to the same bank.
    assert_bank_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !(issue && (issue_bank == $past(issue_bank))));
endmodule

// File: rtl/vbm_bank_array.sv
// Interleaved bank storage.
// BANKS independent word arrays; the low address bits choose the bank and
// the rest the row. Stores write on issue; loads read into a per-bank
// register one cycle after issue, and the selected bank's word is muxed out.
module vbm_bank_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64,
    parameter int BANKS  = 16,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int ROWS   = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_store,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [BANK_W-1:0] bank_sel;
    logic [ROW_W-1:0]  row_sel;
    logic [BANK_W-1:0] sel_q;
    logic [DATA_W-1:0] bank_rd [BANKS];

    assign bank_sel = issue_addr[BANK_W-1:0];
    assign row_sel  = issue_addr[ADDR_W-1:BANK_W];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] mem [ROWS];
        logic [DATA_W-1:0] rd_q;
        logic              hit;

        assign hit = issue && (bank_sel == BANK_W'(g));

        // Write on store issue, register read data on load issue.
        always_ff @(posedge clk) begin
            if (hit && issue_store) begin
                mem[row_sel] <= wr_data;
            end
            if (hit && !issue_store) begin
                rd_q <= mem[row_sel];
            end
        end

        assign bank_rd[g] = rd_q;
    end

    // Remember which bank the last read went to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (issue && !issue_store) begin
            sel_q <= bank_sel;
        end
    end

    assign rd_data = bank_rd[sel_q];
endmodule

// File: rtl/vbm_load_pipe.sv
// Fixed-latency load return pipe.
// Carries valid, element index and last flag for LAT cycles; read data
// joins at stage 1 from the bank array's registered output. Results keep
// issue order. Assumes LAT >= 2.
module vbm_load_pipe #(
    parameter int LAT    = 12,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic              in_last,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    logic              v_q  [LAT];
    logic              l_q  [LAT];
    logic [IDX_W-1:0]  id_q [LAT];
    logic [DATA_W-1:0] dt_q [1:LAT-1];

    for (genvar k = 0; k < LAT; k++) begin : g_stage
        if (k == 0) begin : g_head
            // Capture the issued element's tag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[0] <= 1'b0;
                    l_q[0] <= 1'b0;
                end else begin
                    v_q[0] <= in_valid;
                    l_q[0] <= in_valid && in_last;
                end
                id_q[0] <= in_idx;
            end
        end else begin : g_body
            // Shift tag and data one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[k] <= 1'b0;
                    l_q[k] <= 1'b0;
                end else begin
                    v_q[k] <= v_q[k-1];
                    l_q[k] <= l_q[k-1];
                end
                id_q[k] <= id_q[k-1];
                dt_q[k] <= (k == 1) ? rd_data : dt_q[(k == 1) ? 1 : k-1];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_idx   = id_q[LAT-1];
    assign out_last  = l_q[LAT-1];
    assign out_data  = dt_q[LAT-1];

    // Checker state: previous result index within one vector.
    logic             have_prev_q;
    logic [IDX_W-1:0] prev_idx_q;

    // Track the last presented index for the ordering check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_idx_q  <= '0;
        end else if (out_valid) begin
            have_prev_q <= !out_last;
            prev_idx_q  <= out_idx;
        end
    end

    // R6: results leave in strictly ascending element order.
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_prev_q) |-> (out_idx == prev_idx_q + 1'b1));

    // R6: the first result of a vector is element 0.
    assert_first_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !have_prev_q) |-> (out_idx == '0));
endmodule

// File: rtl/vec_bank_mem.sv
// Interleaved strided vector memory, top level.
// Connects the address generator, per-bank recovery tracker, bank storage
// and load return pipe. One command is served at a time.
module vec_bank_mem #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 64,
    parameter int BANKS    = 16,
    parameter int BUSY_CYC = 4,
    parameter int LOAD_LAT = 12,
    parameter int MAX_VL   = 64,
    localparam int IDX_W   = $clog2(MAX_VL),
    localparam int LEN_W   = IDX_W + 1,
    localparam int BANK_W  = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              stall,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data,
    output logic              done
);
    logic              issue;
    logic              issue_store;
    logic [ADDR_W-1:0] issue_addr;
    logic [IDX_W-1:0]  issue_idx;
    logic              issue_last;
    logic [BANKS-1:0]  bank_busy;
    logic [DATA_W-1:0] rd_data;
    logic              out_last;

    vbm_addr_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .BANKS(BANKS)
    ) u_gen (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_base(cmd_base),
        .cmd_stride(cmd_stride), .cmd_len(cmd_len),
        .bank_busy(bank_busy), .st_valid(st_valid),
        .drain_done(ld_valid && out_last),
        .issue(issue), .issue_store(issue_store), .issue_addr(issue_addr),
        .issue_idx(issue_idx), .issue_last(issue_last),
        .stall(stall), .st_ready(st_ready), .busy(busy), .done(done)
    );

    vbm_bank_track #(
        .BANKS(BANKS), .BUSY_CYC(BUSY_CYC)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .issue_bank(issue_addr[BANK_W-1:0]),
        .bank_busy(bank_busy)
    );

    vbm_bank_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)
    ) u_banks (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .issue_store(issue_store), .issue_addr(issue_addr),
        .wr_data(st_data), .rd_data(rd_data)
    );

    vbm_load_pipe #(
        .LAT(LOAD_LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(issue && !issue_store), .in_idx(issue_idx), .in_last(issue_last),
        .rd_data(rd_data),
        .out_valid(ld_valid), .out_idx(ld_idx), .out_last(out_last), .out_data(ld_data)
    );

    // R7: store data is only taken by an active command.
    assert_ready_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> busy);

    // R10: busy is low in the cycle that completion is signalled.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/sim_vec_bank_mem.sv
// Self-checking bench: stores fill memory, then strided loads and stores
// are checked against a bench memory and a bank-window timing model.
module sim_vec_bank_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_store = 1'b0;
    logic [9:0]  cmd_base = '0;
    logic [9:0]  cmd_stride = '0;
    logic [6:0]  cmd_len = '0;
    logic        busy, stall, st_ready, ld_valid, done;
    logic        st_valid = 1'b0;
    logic [63:0] st_data = '0;
    logic [5:0]  ld_idx;
    logic [63:0] ld_data;

    vec_bank_mem u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
        .busy(busy), .stall(stall), .st_valid(st_valid), .st_data(st_data),
        .st_ready(st_ready), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .done(done)
    );

    always #2.5 clk = ~clk;

    int          cyc = 0;
    int          errors = 0;
    int          checks = 0;
    logic [63:0] refm [1024];
    int          nld, stall_cnt, done_cnt, done_cyc, stcnt, st_tag;
    bit          st_gap;
    int          r_cyc [64];
    int          r_idx [64];
    logic [63:0] r_dat [64];
    int          t_iss [64];
    int          a_el  [64];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] pat(int tag, int i);
        return {16'(tag), 16'(i), 32'hA5A5_0000 ^ 32'(tag * 131 + i * 7)};
    endfunction

    // Output monitor and store data driver, all at the falling edge.
    always @(negedge clk) begin
        if (ld_valid && nld < 64) begin
            r_cyc[nld] = cyc;
            r_idx[nld] = int'(ld_idx);
            r_dat[nld] = ld_data;
        end
        if (ld_valid) nld++;
        if (stall) stall_cnt++;
        if (done) begin done_cnt++; done_cyc = cyc; end
        st_valid = st_gap ? (cyc % 3 != 0) : 1'b1;
        st_data  = pat(st_tag, stcnt);
        if (st_valid && st_ready) stcnt++;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Timing model: earliest cycle for each element given the 4-cycle bank window.
    task automatic model(int t0, int base, int stride, int len, output int stalls);
        int last [16];
        int t = t0;
        for (int b = 0; b < 16; b++) last[b] = -100;
        for (int i = 0; i < len; i++) begin
            int bk;
            a_el[i] = (base + i * stride) & 1023;
            bk = a_el[i] & 15;
            t_iss[i] = (t > last[bk] + 4) ? t : last[bk] + 4;
            last[bk] = t_iss[i];
            t = t_iss[i] + 1;
        end
        stalls = t_iss[len-1] - t0 - (len - 1);
    endtask

    task automatic send(bit st, int base, int stride, int len);
        cmd_valid  = 1'b1;
        cmd_store  = st;
        cmd_base   = 10'(base);
        cmd_stride = 10'(stride);
        cmd_len    = 7'(len);
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_done(int d0);
        int guard = 0;
        while (done_cnt == d0 && guard < 5000) begin @(negedge clk); guard++; end
    endtask

    task automatic run_store(int base, int stride, int len, int tag, bit gap);
        int t0, d0, exp_st;
        @(negedge clk);
        st_tag = tag; st_gap = gap; stcnt = 0; stall_cnt = 0; nld = 0;
        t0 = cyc; d0 = done_cnt;
        send(1'b1, base, stride, len);
        wait_done(d0);
        model(t0 + 1, base, stride, len, exp_st);
        chk(stcnt == len, "R7", "store handshakes", stcnt, len);
        chk(done_cnt == d0 + 1, "R10", "store done pulses", done_cnt - d0, 1);
        if (!gap) begin
            chk(done_cyc == t_iss[len-1] + 1, "R10", "store done cycle", done_cyc, t_iss[len-1] + 1);
            chk(stall_cnt == exp_st, (stride == 1) ? "R4" : "R5", "store stall cycles", stall_cnt, exp_st);
        end
        chk(nld == 0, "R7", "no load results on store", nld, 0);
        for (int i = 0; i < len; i++) refm[a_el[i]] = pat(tag, i);
        st_gap = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_load(int base, int stride, int len, string req, bit inject);
        int t0, d0, exp_st, bad;
        @(negedge clk);
        stall_cnt = 0; nld = 0;
        t0 = cyc; d0 = done_cnt;
        send(1'b0, base, stride, len);
        if (inject) begin
            repeat (2) @(negedge clk);
            st_tag = 999;
            send(1'b1, 512, 1, 8);
        end
        wait_done(d0);
        model(t0 + 1, base, stride, len, exp_st);
        chk(nld == len, "R8", "load result count", nld, len);
        chk(done_cyc == t_iss[len-1] + 13, "R10", "load done cycle", done_cyc, t_iss[len-1] + 13);
        chk(stall_cnt == exp_st, "R5", "load stall cycles", stall_cnt, exp_st);
        bad = 0;
        for (int i = 0; i < len && i < nld; i++) begin
            if (r_idx[i] != i) begin
                bad++; $display("FAIL R6 %s idx: actual=%0d expected=%0d", req, r_idx[i], i);
            end
            if (r_cyc[i] != t_iss[i] + 12) begin
                bad++; $display("FAIL R6 %s cycle of elem %0d: actual=%0d expected=%0d", req, i, r_cyc[i], t_iss[i] + 12);
            end
            if (r_dat[i] !== refm[a_el[i]]) begin
                bad++; $display("FAIL %s data elem %0d: actual=%0h expected=%0h", req, i, r_dat[i], refm[a_el[i]]);
            end
        end
        checks++;
        if (bad != 0) errors++;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        st_tag = 0; st_gap = 0; stcnt = 0; nld = 0; stall_cnt = 0; done_cnt = 0; done_cyc = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy && !stall && !st_ready && !ld_valid && !done, "R12", "outputs in reset",
            {busy, stall, st_ready, ld_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R12", "idle after reset", {busy, done}, 0);

        // R1 R4: fill all 1024 words with unit-stride stores.
        for (int k = 0; k < 16; k++) run_store(k * 64, 1, 64, k + 1, 1'b0);

        // R1 R2 R4 R6: loads over several strides.
        run_load(0,    1,   64, "R4", 1'b0);
        run_load(5,    3,   20, "R2", 1'b0);
        run_load(7,    16,  10, "R3", 1'b0);
        run_load(9,    8,   33, "R3", 1'b0);
        run_load(3,    2,   64, "R2", 1'b0);
        run_load(0,    17,  64, "R1", 1'b0);
        run_load(10,   -1,  30, "R2", 1'b0);
        run_load(1020, 5,   12, "R2", 1'b0);
        run_load(12,   -16, 5,  "R2", 1'b0);
        run_load(33,   1,   1,  "R8", 1'b0);
        // R9: zero stride load
        run_load(100,  0,   6,  "R9", 1'b0);

        // R9 R7: zero-stride store with data gaps, last element wins.
        run_store(200, 0, 5, 40, 1'b1);
        run_load(200, 1, 1, "R9", 1'b0);
        // R7: strided store with gaps, then check every word.
        run_store(300, 5, 30, 41, 1'b1);
        run_load(300, 5, 30, "R7", 1'b0);
        // R5: strided store without gaps checks stall timing.
        run_store(40, 32, 20, 42, 1'b0);
        run_load(40, 32, 20, "R5", 1'b0);

        // R11: a store command during a load is ignored.
        run_load(0, 1, 64, "R11", 1'b1);
        run_load(512, 1, 8, "R11", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule